// File: doc/BRIEF.md
# Center-Aligned PWM Timer Channel

This block is one timer with a single up/down counter and one compare channel. The counter climbs from zero to a programmable top value and then falls back to zero. Each lap therefore takes twice the top value in clock cycles, and the waveform is symmetric about the bottom of the count. The channel compares the count with a programmable threshold. At every equality it either sets or clears its output, depending on a two-bit output-mode field and on whether the counter is rising or falling. The result is a pulse centred on count zero, twice the threshold wide.

The top value and the threshold are written on plain input ports. They are copied into working registers only at the top of the count, or at any time while the timer is stopped, so a new setting never cuts a period in half. Two sticky status flags are provided: one for a compare hit and one for the top of the count. Each is cleared by a one-cycle strobe. The compare flag can also raise an interrupt request.

The counter is a two-state machine. ST_RISE increments the count until it reaches the top value, then takes the TOP turn into ST_FALL. ST_FALL decrements down to zero, then takes the BOTTOM turn back into ST_RISE. Each state loops on itself between turns, and both states hold still while the timer is disabled. Each enabled cycle, the channel output logic picks one of four decisions: LV_KEEP (hold), LV_ACTIVE (drive the active level), LV_REST (drive the inactive level) or LV_OFF (output released).

Top module: `cpwm_timer`

## Requirements
- R1: After reset the count is 0 in ST_RISE. While enabled, the count steps up by one per cycle until it equals the working top value M. It then steps down by one per cycle to 0 and turns back up, so each lap lasts 2*M cycles. When M is 0 the count stays at 0.
- R2: With mode 2'b10 and a working threshold C where 0 < C < M, the output becomes 1 in the cycle after a hit (count equals C) while falling. It becomes 0 in the cycle after a hit while rising. The output is therefore high for 2*C cycles of every lap.
- R3: With mode 2'b01 or 2'b11, the levels of R2 are swapped: 0 after a falling hit and 1 after a rising hit. The output is low for 2*C cycles of every lap.
- R4: With mode 2'b00, the output-enable port and the output are both 0. Hits still set the compare flag.
- R5: The compare flag becomes 1 in the cycle after any hit, whether the count is rising or falling. It stays set until a clear strobe. If a clear strobe and a hit arrive in the same cycle, the flag stays set.
- R6: The interrupt request is 1 exactly when the compare flag and the interrupt enable are both 1.
- R7: The top flag becomes 1 in the cycle after the count equals M while rising. It is sticky and is cleared by its own strobe, and a new top event in the same cycle wins over the clear.
- R8: A new top value or threshold is used only from the cycle after a top event, or from the next cycle while the timer is disabled.
- R9: With C = 0 the output stays at the inactive level of its mode. With C >= M it stays at the active level (1 in mode 2'b10).
- R10: While the enable is 0, the count, direction, output and flags do not change, except for clear strobes.
- R11: During reset the count, direction, output and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Counter enable |
| mod_val | input | CNT_W | Requested top value |
| cmp_val | input | CNT_W | Requested threshold |
| sel | input | 2 | Output mode: 00 released, 10 high-true, x1 low-true |
| ch_ie | input | 1 | Compare interrupt enable |
| ch_clr | input | 1 | Compare flag clear strobe |
| ovf_clr | input | 1 | Top flag clear strobe |
| cnt_o | output | CNT_W | Current count |
| cnt_down_o | output | 1 | 1 while in ST_FALL |
| pwm_o | output | 1 | Channel output |
| pwm_oe_o | output | 1 | Output enable (0 in mode 00) |
| ch_flag_o | output | 1 | Sticky compare flag |
| ch_irq_o | output | 1 | Compare interrupt request |
| ovf_flag_o | output | 1 | Sticky top flag |

## Verification
The threshold 5 with top 8 is run in the high-true mode, in both low-true encodings and in the released mode. Comparing these runs separates errors in the direction-dependent level choice from errors in the count itself. A threshold and top value written part-way through a lap show whether the working copies change at the wrong moment. The threshold 0 and a threshold above the top value expose missing clamps at the duty-cycle extremes. Stretches with the clear strobes held high over hit cycles tell a set-wins flag from a clear-wins one. A disabled stretch and a zero top value probe the frozen and degenerate counter paths.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

    // Counter direction states
    typedef enum logic [0:0] {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } cnt_state_e;

    // Per-cycle decision for the channel output register
    typedef enum logic [1:0] {
        LV_KEEP   = 2'b00,
        LV_ACTIVE = 2'b01,
        LV_REST   = 2'b10,
        LV_OFF    = 2'b11
    } lvl_e;

    localparam logic [1:0] SEL_RELEASED = 2'b00;

endpackage

// File: rtl/cpwm_shadow.sv
`timescale 1ns/1ps
module cpwm_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] mod_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic [CNT_W-1:0] mod_q,
    output logic [CNT_W-1:0] cmp_q
);

    // Working copies follow the requested values only at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0;
            cmp_q <= '0;
        end else if (load) begin
            mod_q <= mod_in;
            cmp_q <= cmp_in;
        end
    end

endmodule

// File: rtl/cpwm_counter.sv
`timescale 1ns/1ps
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] mod_q,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fall_o,
    output logic             top_ev_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             top_ev;

    // Next-state and next-count decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        top_ev  = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_RISE: begin
                    if (cnt_q >= mod_q) begin
                        top_ev = 1'b1;
                        if (mod_q == ZERO) begin
                            cnt_d = ZERO;
                        end else begin
                            state_d = ST_FALL;          // TOP turn
                            cnt_d   = cnt_q - ONE;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == ZERO) begin
                        if (mod_q != ZERO) begin
                            state_d = ST_RISE;          // BOTTOM turn
                            cnt_d   = ONE;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        cnt_o    = cnt_q;
        fall_o   = (state_q == ST_FALL);
        top_ev_o = top_ev;
    end

    AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == ST_RISE && cnt_q >= mod_q && mod_q != ZERO |=> state_q == ST_FALL); // R1
    AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == ST_FALL && cnt_q == ZERO && mod_q != ZERO |=> state_q == ST_RISE && cnt_q == ONE); // R1
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q) && $stable(state_q)); // R10

endmodule

// File: rtl/cpwm_channel.sv
`timescale 1ns/1ps
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] mod_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic [1:0]       sel,
    output logic             hit_o,
    output logic             pwm_o,
    output logic             pwm_oe_o
);

    lvl_e lvl;
    logic hit;
    logic pwm_q, pwm_d;
    logic act_lvl;

    // Decision per cycle
    always_comb begin
        hit     = en && (cnt_i == cmp_q);
        act_lvl = ~sel[0];
        lvl     = LV_KEEP;
        if (!en) begin
            lvl = LV_KEEP;
        end else if (sel == SEL_RELEASED) begin
            lvl = LV_OFF;
        end else if (cmp_q == '0) begin
            lvl = LV_REST;
        end else if (cmp_q >= mod_q) begin
            lvl = LV_ACTIVE;
        end else if (hit) begin
            lvl = fall_i ? LV_ACTIVE : LV_REST;
        end
    end

    always_comb begin
        unique case (lvl)
            LV_KEEP:   pwm_d = pwm_q;
            LV_ACTIVE: pwm_d = act_lvl;
            LV_REST:   pwm_d = ~act_lvl;
            LV_OFF:    pwm_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    always_comb begin
        hit_o    = hit;
        pwm_oe_o = (sel != SEL_RELEASED);
        pwm_o    = pwm_q & pwm_oe_o;
    end

    AST_FALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        en && sel != SEL_RELEASED && cmp_q != '0 && cmp_q < mod_q && fall_i && cnt_i == cmp_q
        |=> pwm_q != $past(sel[0])); // R2
    AST_RISE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        en && sel != SEL_RELEASED && cmp_q != '0 && cmp_q < mod_q && !fall_i && cnt_i == cmp_q
        |=> pwm_q == $past(sel[0])); // R3
    AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        en && sel == SEL_RELEASED |=> !pwm_q); // R4

endmodule

// File: rtl/cpwm_flag.sv
`timescale 1ns/1ps
module cpwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set | (flag_q & ~clr);
    end

    assign flag_o = flag_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_o); // R5, R7
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !flag_o); // R5, R7

endmodule

// File: rtl/cpwm_timer.sv
`timescale 1ns/1ps
module cpwm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       sel,
    input  logic             ch_ie,
    input  logic             ch_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_down_o,
    output logic             pwm_o,
    output logic             pwm_oe_o,
    output logic             ch_flag_o,
    output logic             ch_irq_o,
    output logic             ovf_flag_o
);

    logic [CNT_W-1:0] mod_q, cmp_q, cnt;
    logic             fall, top_ev, hit, load;

    assign load = !en || top_ev;

    cpwm_shadow #(.CNT_W(CNT_W)) shadow_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .mod_in (mod_val),
        .cmp_in (cmp_val),
        .mod_q  (mod_q),
        .cmp_q  (cmp_q)
    );

    cpwm_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mod_q    (mod_q),
        .cnt_o    (cnt),
        .fall_o   (fall),
        .top_ev_o (top_ev)
    );

    cpwm_channel #(.CNT_W(CNT_W)) channel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cnt_i    (cnt),
        .fall_i   (fall),
        .mod_q    (mod_q),
        .cmp_q    (cmp_q),
        .sel      (sel),
        .hit_o    (hit),
        .pwm_o    (pwm_o),
        .pwm_oe_o (pwm_oe_o)
    );

    cpwm_flag ch_flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hit),
        .clr    (ch_clr),
        .flag_o (ch_flag_o)
    );

    cpwm_flag ovf_flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (top_ev),
        .clr    (ovf_clr),
        .flag_o (ovf_flag_o)
    );

    assign cnt_o      = cnt;
    assign cnt_down_o = fall;
    assign ch_irq_o   = ch_flag_o & ch_ie;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en && !top_ev |=> $stable(mod_q) && $stable(cmp_q)); // R8
    AST_HIT_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ch_flag_o); // R5

endmodule

// File: tb/cpwm_timer_tb_top.sv
`timescale 1ns/1ps
module cpwm_timer_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] mod_val = '0;
    logic [W-1:0] cmp_val = '0;
    logic [1:0]   sel = 2'b00;
    logic         ch_ie = 1'b0;
    logic         ch_clr = 1'b0;
    logic         ovf_clr = 1'b0;
    logic [W-1:0] cnt_o;
    logic         cnt_down_o, pwm_o, pwm_oe_o, ch_flag_o, ch_irq_o, ovf_flag_o;

    always #2.5 clk = ~clk;

    cpwm_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .mod_val(mod_val), .cmp_val(cmp_val),
        .sel(sel), .ch_ie(ch_ie), .ch_clr(ch_clr), .ovf_clr(ovf_clr),
        .cnt_o(cnt_o), .cnt_down_o(cnt_down_o), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o),
        .ch_flag_o(ch_flag_o), .ch_irq_o(ch_irq_o), .ovf_flag_o(ovf_flag_o)
    );

    typedef struct packed {
        logic [W-1:0] cnt;
        logic dn, pwm, oe, chf, irq, ovf;
    } exp_t;

    exp_t  sbq[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_tag = "R11";
    logic  last_pwm;

    // Requirement-level model state
    int   m_cnt = 0, m_mod = 0, m_cmp = 0;
    bit   m_dn = 0, m_pwm = 0, m_chf = 0, m_ovf = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Driver: applies inputs, pushes the outputs expected after the next edge
    task automatic cyc(input bit e, input bit cc, input bit oc);
        int  n_cnt;
        bit  n_dn, n_pwm, top, hit, act;
        exp_t x;
        @(negedge clk);
        en = e; ch_clr = cc; ovf_clr = oc;
        top   = e && !m_dn && (m_cnt >= m_mod);
        hit   = e && (m_cnt == m_cmp);
        n_cnt = m_cnt; n_dn = m_dn; n_pwm = m_pwm;
        if (e) begin
            if (!m_dn) begin
                if (m_cnt >= m_mod) begin
                    if (m_mod == 0) n_cnt = 0;
                    else begin n_dn = 1; n_cnt = m_cnt - 1; end
                end else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin
                    if (m_mod != 0) begin n_dn = 0; n_cnt = 1; end
                end else n_cnt = m_cnt - 1;
            end
            act = !sel[0];
            if (sel == 2'b00) n_pwm = 0;
            else if (m_cmp == 0) n_pwm = !act;
            else if (m_cmp >= m_mod) n_pwm = act;
            else if (hit) n_pwm = m_dn ? act : !act;
        end
        m_chf = hit | (m_chf & !cc);
        m_ovf = top | (m_ovf & !oc);
        if (!e || top) begin m_mod = int'(mod_val); m_cmp = int'(cmp_val); end
        m_cnt = n_cnt; m_dn = n_dn; m_pwm = n_pwm;
        x.cnt = W'(m_cnt); x.dn = m_dn; x.oe = (sel != 2'b00);
        x.pwm = x.oe ? m_pwm : 1'b0;
        x.chf = m_chf; x.irq = m_chf & ch_ie; x.ovf = m_ovf;
        sbq.push_back(x);
        @(posedge clk);
        #1 last_pwm = pwm_o;
    endtask

    // Monitor: pops and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(cnt_o == e.cnt,      {cur_tag, " R1"}, "cnt",  int'(cnt_o), int'(e.cnt));
                chk(cnt_down_o == e.dn,  {cur_tag, " R1"}, "dir",  int'(cnt_down_o), int'(e.dn));
                chk(pwm_o == e.pwm,      {cur_tag, " R2"}, "pwm",  int'(pwm_o), int'(e.pwm));
                chk(pwm_oe_o == e.oe,    {cur_tag, " R4"}, "oe",   int'(pwm_oe_o), int'(e.oe));
                chk(ch_flag_o == e.chf,  {cur_tag, " R5"}, "chf",  int'(ch_flag_o), int'(e.chf));
                chk(ch_irq_o == e.irq,   {cur_tag, " R6"}, "irq",  int'(ch_irq_o), int'(e.irq));
                chk(ovf_flag_o == e.ovf, {cur_tag, " R7"}, "ovf",  int'(ovf_flag_o), int'(e.ovf));
            end
        end
    end

    task automatic run(input int n, input bit e);
        for (int i = 0; i < n; i++) cyc(e, (i % 7) == 3, (i % 5) == 2);
    endtask

    task automatic measure(input int n, input int exp_hi, input string req);
        int hi = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            if (last_pwm) hi++;
        end
        chk(hi == exp_hi, req, "high cycles per lap", hi, exp_hi);
    endtask

    initial begin
        int top_seen;
        int zero_seen;
        logic [W-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values
        chk(cnt_o == '0,      "R11", "cnt",  int'(cnt_o), 0);
        chk(!cnt_down_o,      "R11", "dir",  int'(cnt_down_o), 0);
        chk(!pwm_o,           "R11", "pwm",  int'(pwm_o), 0);
        chk(!ch_flag_o && !ovf_flag_o, "R11", "flags", int'(ch_flag_o | ovf_flag_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1, R2: high-true mode, top 8, threshold 5
        cur_tag = "R1/R2"; mod_val = 8; cmp_val = 5; sel = 2'b10; ch_ie = 1;
        cyc(0, 0, 0);
        run(40, 1);
        measure(16, 10, "R2");
        top_seen = 0; zero_seen = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(1, 0, 0);
            if (cnt_o == 8) top_seen++;
            if (cnt_o == 0) zero_seen++;
        end
        chk(top_seen == 1 && zero_seen == 1, "R1", "top/bottom visits per lap", top_seen * 10 + zero_seen, 11);

        // R5, R7: clear strobes held high across hits and top events
        cur_tag = "R5/R7";
        for (int i = 0; i < 20; i++) cyc(1, 1, 1);
        run(10, 1);

        // R3: low-true encodings
        cur_tag = "R3"; sel = 2'b01;
        run(20, 1);
        measure(16, 6, "R3");
        sel = 2'b11;
        run(20, 1);
        measure(16, 6, "R3");

        // R4, R6: released output, flags and interrupt still active
        cur_tag = "R4/R6"; sel = 2'b00;
        run(24, 1);
        ch_ie = 0; run(8, 1); ch_ie = 1; run(8, 1);
        measure(16, 0, "R4");

        // R8: new values written mid-lap take effect at the top
        cur_tag = "R8"; sel = 2'b10;
        run(20, 1);
        mod_val = 6; cmp_val = 2;
        run(30, 1);
        measure(12, 4, "R8");

        // R9: duty extremes
        cur_tag = "R9"; cmp_val = 0;
        run(20, 1);
        measure(12, 0, "R9");
        cmp_val = 9;
        run(20, 1);
        measure(12, 12, "R9");

        // R10: disabled timer holds
        cur_tag = "R10";
        held = cnt_o;
        for (int i = 0; i < 10; i++) cyc(0, 0, 0);
        chk(cnt_o == held, "R10", "cnt frozen", int'(cnt_o), int'(held));
        run(10, 1);

        // R1: zero top value keeps the count at 0
        cur_tag = "R1"; mod_val = 0; cmp_val = 3;
        run(30, 1);
        chk(cnt_o == '0, "R1", "cnt with zero top", int'(cnt_o), 0);

        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule